// File: doc/BRIEF.md
# Transmit Readback Bit-Error Monitor

This block watches a node on a half-duplex, wired-AND serial bus while that node drives the line. On each bit's sample strobe it compares the value the node drove with the value read back from the bus. Which bits are compared depends on the part of the frame being sent. In the header byte only the framing bits (start and stop) are compared, because other nodes may legitimately overwrite the identifier bits. In the response bytes every start, data and stop bit is compared.

A mismatch raises a sticky bit-error flag. A mismatch on a stop bit also raises a frame-error flag, which is a subset of the bit error. An ignore control decides what happens next. With ignore low, the first error of a frame emits a one-cycle abort pulse and a clear of both transmit commands, and the done indications are held off for the rest of the frame. With ignore high, the frame runs to completion and only the flags record the fault.

The bit clock, the arbitration retry logic and the CRC logic are outside this block. The transmit sequencer supplies the phase, the bit position and the strobe, and it consumes the abort and the gated done signals.

Top module: `tx_readback_mon`

## Requirements
- R1: When `hdr_phase_i`=1, only bit position 0 (start) and position DATA_BITS+1 (stop) are compared; a mismatch at positions 1..DATA_BITS leaves both flags at 0.
- R2: When `hdr_phase_i`=0, positions 0 through DATA_BITS+1 are all compared; a mismatch at any of them sets `bit_err_o`.
- R3: A comparison takes place only in a cycle with `sample_i`=1 and `tx_active_i`=1; positions above DATA_BITS+1 are never compared.
- R4: A compared mismatch (`tx_bit_i` != `rx_bit_i`) sets `bit_err_o` at the next rising clock edge; the flag then stays 1 until it is cleared.
- R5: A mismatch at the stop position also sets `frm_err_o` at the same edge; a mismatch at any other position does not set it.
- R6: A 1 on `clr_bit_err_i` clears `bit_err_o` and `frm_err_o` at the next edge; a 1 on `clr_frm_err_i` clears only `frm_err_o`. A set in the same cycle takes priority over a clear.
- R7: With `ignore_err_i`=0, the first mismatch after `frame_start_i` makes `abort_o` and both bits of `cmd_clr_o` (bit 0 header command, bit 1 response command) 1 for exactly the one cycle after the sample edge. Further mismatches before the next `frame_start_i` produce no pulse.
- R8: With `ignore_err_i`=0, `hdr_done_o` and `rsp_done_o` are forced to 0 from the erroring sample cycle until the next `frame_start_i`.
- R9: With `ignore_err_i`=1, a mismatch produces no abort and no command clear, and `hdr_done_o`/`rsp_done_o` follow their request inputs. The flags are still set.
- R10: After reset all outputs are 0 while the done requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_active_i | input | 1 | Node is currently driving the bus |
| sample_i | input | 1 | Bit sample strobe |
| hdr_phase_i | input | 1 | 1 = header byte, 0 = response byte |
| bit_pos_i | input | POS_W | 0 start, 1..DATA_BITS data, DATA_BITS+1 stop |
| tx_bit_i | input | 1 | Value driven by the node |
| rx_bit_i | input | 1 | Value read back from the bus |
| ignore_err_i | input | 1 | 1 = let the frame finish despite errors |
| frame_start_i | input | 1 | Start of a new frame; re-arms the abort |
| hdr_done_req_i | input | 1 | Header-done request from the sequencer |
| rsp_done_req_i | input | 1 | Response-done request from the sequencer |
| clr_bit_err_i | input | 1 | Write-1-to-clear for both flags |
| clr_frm_err_i | input | 1 | Write-1-to-clear for the frame-error flag |
| bit_err_o | output | 1 | Sticky bit-error flag |
| frm_err_o | output | 1 | Sticky stop-bit frame-error flag |
| abort_o | output | 1 | One-cycle abort request |
| cmd_clr_o | output | 2 | Command clear pulse {response, header} |
| hdr_done_o | output | 1 | Gated header-done indication |
| rsp_done_o | output | 1 | Gated response-done indication |

## Verification
The bench builds the block with DATA_BITS=4, which gives a 3-bit position field. Positions 0..7 therefore cover start, all four data slots, stop and two out-of-range codes. For that configuration it sweeps every combination of phase, position, driven value, read-back value and ignore setting. The expected flags, pulses and done gating are computed from the position arithmetic, so the masking boundaries, the stop-only frame error and the single abort per frame are all exercised. Directed cases add the inactive-transmit and missing-strobe filtering and the clear-versus-set priority.

// File: rtl/txbe_pkg.sv
package txbe_pkg;
  typedef enum logic [1:0] {
    SLOT_START = 2'd0,
    SLOT_DATA  = 2'd1,
    SLOT_STOP  = 2'd2,
    SLOT_NONE  = 2'd3
  } slot_e;

  function automatic slot_e slot_of(int unsigned pos, int unsigned nbits);
    if (pos == 0)              return SLOT_START;
    else if (pos <= nbits)     return SLOT_DATA;
    else if (pos == nbits + 1) return SLOT_STOP;
    else                       return SLOT_NONE;
  endfunction
endpackage

// File: rtl/txbe_slot_mask.sv
module txbe_slot_mask
  import txbe_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int POS_W     = 4
) (
  input  logic             hdr_i,
  input  logic [POS_W-1:0] pos_i,
  output logic             cmp_en_o,
  output logic             stop_o
);
  localparam int NPOS = 1 << POS_W;

  logic [NPOS-1:0] hdr_en, rsp_en, stop_v;

  for (genvar p = 0; p < NPOS; p++) begin : g_pos
    localparam slot_e SL = slot_of(p, DATA_BITS);
    assign rsp_en[p] = (SL != SLOT_NONE);
    assign hdr_en[p] = (SL == SLOT_START) || (SL == SLOT_STOP);
    assign stop_v[p] = (SL == SLOT_STOP);
  end

  assign cmp_en_o = hdr_i ? hdr_en[pos_i] : rsp_en[pos_i];
  assign stop_o   = stop_v[pos_i];

  // header data slots are never compared
  always_comb begin
    if (hdr_i && pos_i > POS_W'(0) && pos_i <= POS_W'(DATA_BITS))
      p_hdr_data_masked_r1: assert (!cmp_en_o);
  end
endmodule

// File: rtl/txbe_sticky_flag.sv
module txbe_sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end

  p_rise_needs_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(set_i));
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && !clr_i |=> flag_o);
endmodule

// File: rtl/txbe_abort_ctl.sv
module txbe_abort_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic err_i,
  input  logic ignore_i,
  input  logic frame_start_i,
  output logic abort_o,
  output logic fault_o
);
  logic fault_q, abort_now;

  assign abort_now = err_i & ~ignore_i & ~fault_q;
  assign fault_o   = fault_q | abort_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q <= 1'b0;
      abort_o <= 1'b0;
    end else begin
      abort_o <= abort_now;
      if (abort_now)          fault_q <= 1'b1;
      else if (frame_start_i) fault_q <= 1'b0;
    end
  end

  p_abort_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o);
  p_abort_not_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> $past(!ignore_i));
endmodule

// File: rtl/tx_readback_mon.sv
module tx_readback_mon #(
  parameter  int DATA_BITS = 8,
  localparam int POS_W     = $clog2(DATA_BITS + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_active_i,
  input  logic             sample_i,
  input  logic             hdr_phase_i,
  input  logic [POS_W-1:0] bit_pos_i,
  input  logic             tx_bit_i,
  input  logic             rx_bit_i,
  input  logic             ignore_err_i,
  input  logic             frame_start_i,
  input  logic             hdr_done_req_i,
  input  logic             rsp_done_req_i,
  input  logic             clr_bit_err_i,
  input  logic             clr_frm_err_i,
  output logic             bit_err_o,
  output logic             frm_err_o,
  output logic             abort_o,
  output logic [1:0]       cmd_clr_o,
  output logic             hdr_done_o,
  output logic             rsp_done_o
);
  logic cmp_en, is_stop, mismatch, fault;

  txbe_slot_mask #(.DATA_BITS(DATA_BITS), .POS_W(POS_W)) i_mask (
    .hdr_i    (hdr_phase_i),
    .pos_i    (bit_pos_i),
    .cmp_en_o (cmp_en),
    .stop_o   (is_stop)
  );

  assign mismatch = sample_i & tx_active_i & cmp_en & (tx_bit_i ^ rx_bit_i);

  txbe_sticky_flag i_bit_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (mismatch),
    .clr_i  (clr_bit_err_i),
    .flag_o (bit_err_o)
  );

  // clearing the bit error also clears its subset
  txbe_sticky_flag i_frm_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (mismatch & is_stop),
    .clr_i  (clr_frm_err_i | clr_bit_err_i),
    .flag_o (frm_err_o)
  );

  txbe_abort_ctl i_abort (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .err_i         (mismatch),
    .ignore_i      (ignore_err_i),
    .frame_start_i (frame_start_i),
    .abort_o       (abort_o),
    .fault_o       (fault)
  );

  assign cmd_clr_o  = {2{abort_o}};
  assign hdr_done_o = hdr_done_req_i & ~fault;
  assign rsp_done_o = rsp_done_req_i & ~fault;

  p_frm_subset_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_err_o |-> bit_err_o);
  p_done_gated_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> !hdr_done_o && !rsp_done_o);
  p_idle_no_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_err_o && !tx_active_i |=> !bit_err_o);
endmodule

// File: tb/test_tx_readback_mon.sv
module test_tx_readback_mon;
  localparam int DB    = 4;
  localparam int POS_W = $clog2(DB + 2);

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_active = 0, sample = 0, hdr = 0, tx_b = 0, rx_b = 0, ign = 0;
  logic fstart = 0, hreq = 0, rreq = 0, clr_b = 0, clr_f = 0;
  logic [POS_W-1:0] pos = '0;
  logic bit_err, frm_err, abort;
  logic [1:0] cmd_clr;
  logic hdone, rdone;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  tx_readback_mon #(.DATA_BITS(DB)) i_tx_readback_mon (
    .clk_i(clk), .rst_ni(rst_n), .tx_active_i(tx_active), .sample_i(sample),
    .hdr_phase_i(hdr), .bit_pos_i(pos), .tx_bit_i(tx_b), .rx_bit_i(rx_b),
    .ignore_err_i(ign), .frame_start_i(fstart), .hdr_done_req_i(hreq),
    .rsp_done_req_i(rreq), .clr_bit_err_i(clr_b), .clr_frm_err_i(clr_f),
    .bit_err_o(bit_err), .frm_err_o(frm_err), .abort_o(abort),
    .cmd_clr_o(cmd_clr), .hdr_done_o(hdone), .rsp_done_o(rdone)
  );

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // new frame with both flags cleared
  task automatic new_frame();
    @(negedge clk);
    fstart = 1; clr_b = 1; sample = 0; hreq = 0; rreq = 0;
    @(negedge clk);
    fstart = 0; clr_b = 0;
  endtask

  task automatic sweep_case(bit h, int p, bit t, bit r, bit ig);
    bit cmp, err, stop, kill;
    stop = (p == DB + 1);
    cmp  = (p == 0) || stop || (!h && p >= 1 && p <= DB);
    err  = cmp && (t != r);
    kill = err && !ig;
    new_frame();
    check("R6 cleared at frame start", {2'b0, bit_err, frm_err}, 4'h0);
    tx_active = 1; sample = 1; hdr = h; pos = POS_W'(p);
    tx_b = t; rx_b = r; ign = ig; hreq = 1; rreq = 1;
    #2;
    check(ig ? "R9 done pass same cycle" : "R8 done gated same cycle",
          {2'b0, hdone, rdone}, {2'b0, !kill, !kill});
    @(negedge clk);
    sample = 0;
    check(h ? "R1 header bit error" : "R2 response bit error", {3'b0, bit_err}, {3'b0, err});
    check("R5 stop frame error", {3'b0, frm_err}, {3'b0, err && stop});
    check(ig ? "R9 no abort" : "R7 abort pulse", {1'b0, abort, cmd_clr}, {1'b0, kill, kill, kill});
    check(ig ? "R9 done follows req" : "R8 done held off",
          {2'b0, hdone, rdone}, {2'b0, !kill, !kill});
    sample = 1;
    @(negedge clk);
    sample = 0;
    check("R7 no second abort in frame", {1'b0, abort, cmd_clr}, 4'h0);
    check("R4 sticky bit error", {3'b0, bit_err}, {3'b0, err});
    hreq = 0; rreq = 0; tx_active = 0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R10 reset outputs",
          {bit_err, frm_err, abort, hdone}, 4'h0);
    check("R10 reset outputs b", {rdone, 1'b0, cmd_clr}, 4'h0);
    rst_n = 1;

    for (int h = 0; h < 2; h++)
      for (int p = 0; p < (1 << POS_W); p++)
        for (int t = 0; t < 2; t++)
          for (int r = 0; r < 2; r++)
            for (int ig = 0; ig < 2; ig++)
              sweep_case(h[0], p, t[0], r[0], ig[0]);

    // R3: mismatch with transmit inactive or no strobe is not compared
    new_frame();
    tx_active = 0; sample = 1; hdr = 0; pos = 0; tx_b = 1; rx_b = 0; ign = 0;
    @(negedge clk);
    check("R3 inactive not compared", {2'b0, bit_err, abort}, 4'h0);
    tx_active = 1; sample = 0;
    @(negedge clk);
    check("R3 no strobe not compared", {2'b0, bit_err, abort}, 4'h0);

    // R6: stop mismatch then clear frame flag only
    sample = 1; pos = POS_W'(DB + 1);
    @(negedge clk);
    sample = 0;
    check("R5 stop sets both", {2'b0, bit_err, frm_err}, 4'h3);
    clr_f = 1;
    @(negedge clk);
    clr_f = 0;
    check("R6 frame clear only", {2'b0, bit_err, frm_err}, 4'h2);
    // set and clear in the same cycle: set wins
    sample = 1; clr_b = 1;
    @(negedge clk);
    sample = 0; clr_b = 0;
    check("R6 set beats clear", {2'b0, bit_err, frm_err}, 4'h3);
    clr_b = 1;
    @(negedge clk);
    clr_b = 0;
    check("R6 bit clear clears both", {2'b0, bit_err, frm_err}, 4'h0);
    tx_active = 0;
    // R7: after frame_start, abort re-arms
    new_frame();
    tx_active = 1; sample = 1; pos = 0; tx_b = 1; rx_b = 0; ign = 0;
    @(negedge clk);
    sample = 0;
    check("R7 re-armed abort", {3'b0, abort}, 4'h1);
    tx_active = 0;
    @(negedge clk);
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    report();
  end
endmodule